// File: doc/BRIEF.md
# Adaptive ADPCM Nibble Decoder

This block turns a stream of 4-bit ADPCM codes into signed sample values for a 9-bit DAC. It holds two pieces of state: a 4-bit adaptation level and a running signed sample. Each accepted code adds one step to the running sample. The step comes from a 16-by-8 magnitude table: the adaptation level picks the row and the low three bits of the code pick the column. The top bit of the code gives the sign. The level then moves by a small signed amount that depends only on the low three code bits, and it is held within 0 to 15.

An upstream engine presents one code per cycle with a valid strobe. It pulses the clear input at the start of every new sound, so that both the level and the sample begin at zero. The sample output is a register. It shows the effect of a code on the clock edge at which that code is accepted.

Top module: `adpcm_nibble_decoder`

## Requirements
- R1: After reset, `sample_o` is 0 and the adaptation level is 0, so code 7 as the first code yields +10.
- R2: When `clear_i` is high at a clock edge, the sample and the level both become 0 and any code offered in that cycle is dropped. `clear_i` has priority over `nib_valid_i`.
- R3: For a code with bit 3 = 0, the sample increases by the magnitude in row = level and column = code[2:0]. Row 0 is 0,0,1,2,3,5,7,10 and row 15 is 6,20,36,54,76,104,144,214 for columns 0 to 7.
- R4: For a code with bit 3 = 1, the sample decreases by the magnitude in the same row and column code[2:0].
- R5: After each accepted code, the level changes by -1,-1,0,0,+1,+2,+2,+3 for code[2:0] = 0..7, whatever the value of bit 3.
- R6: The level never rises above 15. An increase from a high level stops at 15.
- R7: The level never falls below 0. A decrease from level 0 leaves it at 0.
- R8: The sample saturates at +255 and -256 and does not wrap.
- R9: In a cycle with `nib_valid_i` low and `clear_i` low, the sample and the level hold their values.
- R10: The step is read with the level held before the code, not with the level updated by that code.
- R11: The output changes on the first rising edge at which `nib_valid_i` is seen high, so it can be sampled one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Starts a new sound: zeroes the sample and the level |
| nib_valid_i | input | 1 | A code is present on `nib_i` this cycle |
| nib_i | input | 4 | ADPCM code: bit 3 is the sign, bits 2:0 are the magnitude class |
| sample_o | output | 9 | Registered signed sample for the DAC |

## Verification
The level is hidden, so a wrong level appears at the ports only through the size of later steps. The first code after the fault moves the sample by a wrong amount, and the output shows this one cycle after the strobe. Failures of the clamp at 15 or at 0 do not appear until a code whose step in the current row differs from the step in the row the level should hold. For this reason the vectors drive the level to both limits and then probe it with codes whose steps differ sharply between adjacent rows. A wrong sign or saturation path gives a wrong sample at once, on the same edge.

// File: rtl/adpcm_dec_pkg.sv
package adpcm_dec_pkg;
  localparam int CODE_W    = 4;
  localparam int MAG_W     = CODE_W - 1;
  localparam int STATE_W   = 4;
  localparam int STEP_W    = 8;
  localparam int SAMPLE_W  = 9;
  localparam int COLS      = 1 << MAG_W;
  localparam int ROW_BITS  = COLS * STEP_W;
  localparam int MAX_STATE = (1 << STATE_W) - 1;
  localparam int SMP_MAX   = (1 << (SAMPLE_W - 1)) - 1;
  localparam int SMP_MIN   = -(1 << (SAMPLE_W - 1));

  typedef logic [STATE_W-1:0]         level_t;
  typedef logic [STEP_W-1:0]          step_t;
  typedef logic signed [SAMPLE_W-1:0] sample_t;

  // level movement per magnitude class
  function automatic int level_delta(input logic [MAG_W-1:0] mag);
    case (mag)
      3'd0, 3'd1: level_delta = -1;
      3'd2, 3'd3: level_delta = 0;
      3'd4:       level_delta = 1;
      3'd5, 3'd6: level_delta = 2;
      default:    level_delta = 3;
    endcase
  endfunction

  function automatic level_t level_clamp(input int v);
    if (v < 0)              level_clamp = '0;
    else if (v > MAX_STATE) level_clamp = level_t'(MAX_STATE);
    else                    level_clamp = level_t'(v);
  endfunction

  function automatic sample_t sample_sat(input int v);
    if (v > SMP_MAX)      sample_sat = sample_t'(SMP_MAX);
    else if (v < SMP_MIN) sample_sat = sample_t'(SMP_MIN);
    else                  sample_sat = sample_t'(v);
  endfunction

  function automatic int signed_step(input step_t mag, input logic neg);
    signed_step = neg ? -int'(mag) : int'(mag);
  endfunction
endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom
  import adpcm_dec_pkg::*;
(
  input  level_t           row_i,
  input  logic [MAG_W-1:0] col_i,
  output step_t            mag_o
);
  logic [ROW_BITS-1:0] row_word;

  // column 0 sits in the low byte of each row word
  always_comb begin
    case (row_i)
      4'd0:    row_word = 64'h0a07050302010000;
      4'd1:    row_word = 64'h0d08060403020100;
      4'd2:    row_word = 64'h0f0a070504020100;
      4'd3:    row_word = 64'h130d090604030100;
      4'd4:    row_word = 64'h170f0b0805030200;
      4'd5:    row_word = 64'h1d130e0a07040200;
      4'd6:    row_word = 64'h2116100c08050300;
      4'd7:    row_word = 64'h2b1d140f0a070401;
      4'd8:    row_word = 64'h352319120d080401;
      4'd9:    row_word = 64'h402b1f16100a0601;
      4'd10:   row_word = 64'h4c33251b130c0702;
      4'd11:   row_word = 64'h60402e2218100902;
      4'd12:   row_word = 64'h754f39291d130b03;
      4'd13:   row_word = 64'h8f60453224180d04;
      4'd14:   row_word = 64'haf76553e2c1d1004;
      default: row_word = 64'hd690684c36241406;
    endcase
  end

  assign mag_o = row_word[col_i*STEP_W +: STEP_W];
endmodule

// File: rtl/adpcm_level_adapt.sv
module adpcm_level_adapt
  import adpcm_dec_pkg::*;
(
  input  level_t           level_i,
  input  logic [MAG_W-1:0] mag_i,
  output level_t           level_nxt_o
);
  assign level_nxt_o = level_clamp(int'(level_i) + level_delta(mag_i));
endmodule

// File: rtl/adpcm_accum.sv
module adpcm_accum
  import adpcm_dec_pkg::*;
(
  input  sample_t acc_i,
  input  step_t   step_i,
  input  logic    neg_i,
  output sample_t acc_nxt_o
);
  assign acc_nxt_o = sample_sat(int'(acc_i) + signed_step(step_i, neg_i));
endmodule

// File: rtl/adpcm_nibble_decoder.sv
module adpcm_nibble_decoder
  import adpcm_dec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       nib_valid_i,
  input  logic [CODE_W-1:0]          nib_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  level_t  level_q;
  level_t  level_nxt;
  step_t   step_mag;
  sample_t acc_q;
  sample_t acc_nxt;
  logic    accept;
  logic    code_neg;

  assign accept   = nib_valid_i & ~clear_i;
  assign code_neg = nib_i[CODE_W-1];

  adpcm_step_rom u_rom (
    .row_i (level_q),
    .col_i (nib_i[MAG_W-1:0]),
    .mag_o (step_mag)
  );

  adpcm_level_adapt u_adapt (
    .level_i     (level_q),
    .mag_i       (nib_i[MAG_W-1:0]),
    .level_nxt_o (level_nxt)
  );

  adpcm_accum u_acc (
    .acc_i     (acc_q),
    .step_i    (step_mag),
    .neg_i     (code_neg),
    .acc_nxt_o (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      level_q <= '0;
      acc_q   <= '0;
    end else if (accept) begin
      level_q <= level_nxt;
      acc_q   <= acc_nxt;
    end
  end

  assign sample_o = acc_q;
endmodule

// File: rtl/adpcm_nibble_decoder_chk.sv
module adpcm_nibble_decoder_chk
  import adpcm_dec_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clear_i,
  input logic                       nib_valid_i,
  input logic [CODE_W-1:0]          nib_i,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input level_t                     level_q,
  input logic                       accept
);
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sample_o == '0) && (level_q == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !nib_valid_i) |=> $stable(sample_o) && $stable(level_q));

  assert_rise_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !nib_i[CODE_W-1]) |=> sample_o >= $past(sample_o));

  assert_fall_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && nib_i[CODE_W-1]) |=> sample_o <= $past(sample_o));

  assert_level_up3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && nib_i[MAG_W-1:0] == 3'd7 && level_q <= 4'd12)
      |=> level_q == $past(level_q) + 4'd3);

  assert_level_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && level_q == 4'd15 && nib_i[MAG_W-1]) |=> level_q == 4'd15);

  assert_level_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && level_q == 4'd0 && nib_i[MAG_W-1:1] == 2'd0) |=> level_q == 4'd0);
endmodule

bind adpcm_nibble_decoder adpcm_nibble_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear_i     (clear_i),
  .nib_valid_i (nib_valid_i),
  .nib_i       (nib_i),
  .sample_o    (sample_o),
  .level_q     (level_q),
  .accept      (accept)
);

// File: tb/adpcm_nibble_decoder_test.sv
`timescale 1ns/1ps
module adpcm_nibble_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear_i = 1'b0;
  logic       nib_valid_i = 1'b0;
  logic [3:0] nib_i = 4'd0;
  logic signed [8:0] sample_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adpcm_nibble_decoder uut (
    .clk (clk), .rst_n (rst_n), .clear_i (clear_i),
    .nib_valid_i (nib_valid_i), .nib_i (nib_i), .sample_o (sample_o)
  );

  localparam int NV = 35;
  // clear, valid, code, expected sample after the edge
  localparam int VEC [NV][4] = '{
    '{0,1,7,10}, '{0,1,7,29}, '{0,1,7,62}, '{0,1,7,126}, '{0,1,7,243},
    '{0,1,7,255},                                        // R8 top
    '{0,1,15,41}, '{0,1,15,-173}, '{0,1,15,-256},        // R4, R8 bottom
    '{0,0,7,-256},                                       // R9
    '{0,1,0,-250}, '{0,1,8,-254}, '{0,1,1,-241}, '{0,1,2,-222},
    '{0,1,4,-181}, '{0,1,12,-231}, '{0,1,5,-146}, '{0,1,6,-2}, // R6 clamp
    '{1,1,7,0},                                          // R2
    '{0,1,1,0}, '{0,1,0,0}, '{0,1,3,2}, '{0,1,2,3},      // R7
    '{0,1,5,8}, '{0,1,13,1}, '{0,1,6,16}, '{0,1,11,8}, '{0,1,10,3},
    '{0,1,9,0}, '{0,1,14,-19}, '{0,1,7,24}, '{0,1,4,51}, '{0,1,0,53},
    '{0,1,3,72}, '{0,1,5,109}
  };

  function automatic string tag_of(input int i);
    if (i < 6)       return "R3 R5 R8 R11";
    else if (i < 9)  return "R4 R6 R8";
    else if (i == 9) return "R9";
    else if (i < 18) return "R5 R6 R10";
    else if (i == 18) return "R2";
    else if (i < 23) return "R7";
    else             return "R3 R4 R5 R10";
  endfunction

  task automatic check(input int exp, input string tag);
    checks++;
    if (int'(sample_o) != exp) begin
      errors++;
      $display("FAIL %s: sample_o actual %0d expected %0d", tag, sample_o, exp);
    end
  endtask

  task automatic step(input bit clr, input bit vld, input int code);
    clear_i = clr; nib_valid_i = vld; nib_i = 4'(code);
    @(negedge clk);
    clear_i = 1'b0; nib_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][0] != 0, VEC[i][1] != 0, VEC[i][2]);
      check(VEC[i][3], tag_of(i));
    end
    // R2: clear together with a code, then level must be 0 again
    step(0, 1, 7); step(0, 1, 7);
    step(1, 1, 7);
    check(0, "R2 clear drops code");
    step(0, 1, 7);
    check(10, "R2 level zero after clear");
    // R1: reset in mid-stream restores level 0
    step(0, 1, 7); step(0, 1, 7);
    rst_n = 1'b0;
    @(negedge clk);
    check(0, "R1 reset mid-stream");
    rst_n = 1'b1;
    step(0, 1, 7);
    check(10, "R1 level zero after reset");
    // R11: output already updated one cycle after the strobe
    step(0, 1, 15);
    check(-9, "R11 one-cycle latency");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule